// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial EEPROM. It drives chip select, a shift clock and a data line into the memory, and it samples the memory's data output. A host supplies a 6-bit word address and a one-cycle start strobe. The block then clocks out an 11-bit read command, clocks in sixteen data bits, and returns the assembled word together with a one-cycle completion strobe. Each line change is held for a programmable number of system clocks, `step_div + 1`, called a step below.

A second entry point builds a 48-bit station address. A single strobe makes the block read words 6, 7, 8 and 9 back to back. The address bytes are rebuilt from pairs of neighbouring words, because the stored image is shifted by one bit across word boundaries. While either kind of transaction runs, the block reports busy and ignores new strobes.

Top module: `ee_addr_fetch`

## Requirements
- R1: After reset and whenever the block is idle, `ee_cs`, `ee_sk` and `ee_di` are low, and `rd_busy`, `rd_done` and `sta_done` are low.
- R2: The command is 11 bits sent most significant bit first. Bits 10:9 are 0, bits 8:6 are the read opcode 3'b110, and bits 5:0 are the word address. Each command bit is placed on `ee_di` during a step with `ee_sk` low. The next step raises `ee_sk`, and `ee_di` does not change at that rising edge.
- R3: Every step lasts exactly `step_div + 1` clock cycles, so every high pulse of `ee_sk` is `step_div + 1` cycles wide.
- R4: A word read takes 57 steps in this order: one select step (cs high, sk low), 22 command steps, one gap step (cs high, sk low), 32 read steps, and one closing step (cs high, sk low). `rd_busy` is therefore high for exactly 57*(step_div+1) cycles.
- R5: Data is gathered least significant bit first. The value of `ee_do` at the end of the high step of the k-th read clock (k = 0..15) becomes bit k of the word.
- R6: `rd_done` is a one-cycle pulse in the first idle cycle. `rd_word` then holds the word until the next transaction starts.
- R7: A `rd_start` or `sta_start` that arrives while `rd_busy` is high has no effect. The running transaction completes with its original address, and no extra transaction follows it.
- R8: `sta_start` reads words 6 through 9 in turn. For j = 0..2, with w = word(7+j) and p = word(6+j), byte 2j is the low 8 bits of (w<<1)+(p>>15) and byte 2j+1 is the low 8 bits of w>>7. Byte n sits at `sta_addr[8n+7:8n]`. `sta_done` pulses for one cycle once the last word is in.
- R9: `ee_sk` is never high while `ee_cs` is low.
- R10: `rd_done` does not pulse during the word reads of a station-address fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_div | input | 8 | Step length minus one, in clock cycles |
| rd_start | input | 1 | Single-word read strobe |
| rd_addr | input | 6 | Word address for a single-word read |
| rd_busy | output | 1 | A transaction is in progress |
| rd_done | output | 1 | Single-word read completed (one cycle) |
| rd_word | output | 16 | Last word read |
| sta_start | input | 1 | Station-address fetch strobe |
| sta_done | output | 1 | Station address ready (one cycle) |
| sta_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The assertions assume that `step_div` stays constant while a transaction runs, and that `ee_do` changes only at rising edges of `ee_sk`. The bench changes `step_div` only while the block is idle. Its memory model updates `ee_do` only on `ee_sk` rising edges, so the value is settled well before the block samples it at the end of the high step. Start strobes are driven on falling clock edges. The bench deliberately lands them inside a running transaction to exercise the rejection path.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

    localparam int ADDR_W    = 6;
    localparam int WORD_W    = 16;
    localparam int CMD_W     = 11;
    localparam int IDX_W     = $clog2(WORD_W);
    localparam logic [2:0] OP_READ = 3'b110;
    localparam int STA_FIRST = 6;
    localparam int STA_WORDS = 4;
    localparam int STA_W     = (STA_WORDS - 1) * WORD_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_CMD,
        PH_GAP,
        PH_READ,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_lines_t;

    function automatic logic [CMD_W-1:0] read_cmd(input logic [ADDR_W-1:0] a);
        return {{(CMD_W - 3 - ADDR_W){1'b0}}, OP_READ, a};
    endfunction

    // Two address bytes rebuilt from a word and its predecessor: {hi, lo}
    function automatic logic [WORD_W-1:0] sta_pair(input logic [WORD_W-1:0] w,
                                                   input logic [WORD_W-1:0] p);
        logic [WORD_W:0] lo_sum;
        logic [WORD_W-1:0] hi_sh;
        lo_sum = ({1'b0, w} << 1) + {{WORD_W{1'b0}}, p[WORD_W-1]};
        hi_sh  = w >> 7;
        return {hi_sh[7:0], lo_sum[7:0]};
    endfunction

endpackage

// File: rtl/ee_step_timer.sv
module ee_step_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] step_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt >= step_div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= step_div);

    // R3: the step counter never runs past the programmed length
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run && $stable(step_div) |-> cnt <= step_div);

endmodule

// File: rtl/ee_word_rd.sv
module ee_word_rd
    import ee_rd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  step_div,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output ee_lines_t         lines
);
    phase_t            phase;
    logic              hi;
    logic [IDX_W-1:0]  idx;
    logic [CMD_W-1:0]  cmd;
    logic              tick;

    assign busy = (phase != PH_IDLE);

    ee_step_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .step_div (step_div),
        .tick     (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            hi    <= 1'b0;
            idx   <= '0;
            cmd   <= '0;
            word  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase <= PH_SEL;
                    cmd   <= read_cmd(addr);
                    idx   <= IDX_W'(CMD_W - 1);
                    hi    <= 1'b0;
                end
            end else if (tick) begin
                unique case (phase)
                    PH_SEL: phase <= PH_CMD;
                    PH_CMD: begin
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi <= 1'b0;
                            if (idx == '0) phase <= PH_GAP;
                            else           idx   <= idx - 1'b1;
                        end
                    end
                    PH_GAP: begin
                        phase <= PH_READ;
                        idx   <= '0;
                        hi    <= 1'b1;
                    end
                    PH_READ: begin
                        if (hi) begin
                            word[idx] <= ee_do;
                            hi        <= 1'b0;
                        end else if (idx == IDX_W'(WORD_W - 1)) begin
                            phase <= PH_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                            hi  <= 1'b1;
                        end
                    end
                    PH_FIN: begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        lines = '0;
        unique case (phase)
            PH_SEL, PH_GAP, PH_FIN: lines.cs = 1'b1;
            PH_CMD: begin
                lines.cs = 1'b1;
                lines.sk = hi;
                lines.di = cmd[idx[$clog2(CMD_W)-1:0]];
            end
            PH_READ: begin
                lines.cs = 1'b1;
                lines.sk = hi;
            end
            default: lines = '0;
        endcase
    end

    // R9: shift clock only with chip select
    a_r9_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
        lines.sk |-> lines.cs);
    // R1: quiet lines while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lines == '0));
    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: data line is steady across a rising shift clock
    a_r2_di_steady: assert property (@(posedge clk) disable iff (rst)
        $rose(lines.sk) |-> $stable(lines.di));
    // R7: a latched command is not replaced mid-transaction
    a_r7_cmd_held: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(cmd));

endmodule

// File: rtl/ee_sta_seq.sv
module ee_sta_seq
    import ee_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              rd_busy,
    input  logic              rd_done,
    input  logic [WORD_W-1:0] rd_word,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              active,
    output logic              sta_done,
    output logic [STA_W-1:0]  sta_addr
);
    localparam int WI_W = $clog2(STA_WORDS);

    logic [WI_W-1:0]   widx;
    logic              waiting;
    logic [WORD_W-1:0] prev;

    assign req      = active && !waiting && !rd_busy;
    assign req_addr = ADDR_W'(STA_FIRST) + ADDR_W'(widx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            widx     <= '0;
            waiting  <= 1'b0;
            prev     <= '0;
            sta_addr <= '0;
            sta_done <= 1'b0;
        end else begin
            sta_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    widx    <= '0;
                    waiting <= 1'b0;
                end
            end else if (req) begin
                waiting <= 1'b1;
            end else if (rd_done) begin
                waiting <= 1'b0;
                prev    <= rd_word;
                if (widx != '0)
                    sta_addr[(int'(widx) - 1) * WORD_W +: WORD_W] <= sta_pair(rd_word, prev);
                if (widx == WI_W'(STA_WORDS - 1)) begin
                    active   <= 1'b0;
                    sta_done <= 1'b1;
                end else begin
                    widx <= widx + 1'b1;
                end
            end
        end
    end

    // R8: only the station words are ever requested
    a_r8_addr_range: assert property (@(posedge clk) disable iff (rst)
        req |-> (req_addr >= ADDR_W'(STA_FIRST)) &&
                (req_addr <= ADDR_W'(STA_FIRST + STA_WORDS - 1)));
    // R8: one word read in flight at a time
    a_r8_one_inflight: assert property (@(posedge clk) disable iff (rst)
        req |=> rd_busy);

endmodule

// File: rtl/ee_addr_fetch.sv
module ee_addr_fetch
    import ee_rd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  step_div,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_busy,
    output logic              rd_done,
    output logic [WORD_W-1:0] rd_word,
    input  logic              sta_start,
    output logic              sta_done,
    output logic [STA_W-1:0]  sta_addr,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic              w_busy, w_done, w_start;
    logic [ADDR_W-1:0] w_addr;
    logic [WORD_W-1:0] w_word;
    ee_lines_t         w_lines;
    logic              s_req, s_active, s_go, host_go;
    logic [ADDR_W-1:0] s_addr;

    assign rd_busy = w_busy || s_active;
    assign host_go = rd_start && !rd_busy;
    assign s_go    = sta_start && !rd_start && !rd_busy;
    assign w_start = host_go || s_req;
    assign w_addr  = s_active ? s_addr : rd_addr;

    ee_word_rd #(.DIV_W(DIV_W)) u_word (
        .clk      (clk),
        .rst      (rst),
        .step_div (step_div),
        .start    (w_start),
        .addr     (w_addr),
        .ee_do    (ee_do),
        .busy     (w_busy),
        .done     (w_done),
        .word     (w_word),
        .lines    (w_lines)
    );

    ee_sta_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (s_go),
        .rd_busy  (w_busy),
        .rd_done  (w_done),
        .rd_word  (w_word),
        .req      (s_req),
        .req_addr (s_addr),
        .active   (s_active),
        .sta_done (sta_done),
        .sta_addr (sta_addr)
    );

    assign rd_done = w_done && !s_active;
    assign rd_word = w_word;
    assign ee_cs   = w_lines.cs;
    assign ee_sk   = w_lines.sk;
    assign ee_di   = w_lines.di;

    // R7: strobes during a transaction never launch a second one
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        w_busy |-> !(host_go || s_go));
    // R6/R8: the two completion strobes never coincide
    a_r10_done_split: assert property (@(posedge clk) disable iff (rst)
        !(rd_done && sta_done));

endmodule

// File: tb/ee_addr_fetch_test.sv
module ee_addr_fetch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  step_div = 8'd0;
    logic        rd_start = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        sta_start = 1'b0;
    logic        ee_do = 1'b0;
    logic        rd_busy, rd_done, sta_done, ee_cs, ee_sk, ee_di;
    logic [15:0] rd_word;
    logic [47:0] sta_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ee_addr_fetch uut (
        .clk(clk), .rst(rst), .step_div(step_div),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_busy(rd_busy),
        .rd_done(rd_done), .rd_word(rd_word), .sta_start(sta_start),
        .sta_done(sta_done), .sta_addr(sta_addr), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] memf(input int a);
        int v;
        v = ((a + 1) * 40503) ^ (a << 9) ^ 16'h5A3C;
        return v[15:0];
    endfunction

    // EEPROM model
    int         sk_rises = 0;
    logic [10:0] cap = '0;
    always @(posedge ee_cs) sk_rises = 0;
    always @(posedge ee_sk) begin
        logic [15:0] mw;
        if (sk_rises < 11) begin
            cap = {cap[9:0], ee_di};
        end else begin
            mw = memf(int'(cap[5:0]));
            ee_do = mw[sk_rises - 11];
        end
        sk_rises++;
    end

    // pulse-width and strobe monitors
    int sk_run = 0, sk_bad = 0, rd_done_n = 0, sta_done_n = 0, bad_gate = 0;
    always @(negedge clk) begin
        if (ee_sk) sk_run++;
        else if (sk_run > 0) begin
            if (sk_run != int'(step_div) + 1) sk_bad++;
            sk_run = 0;
        end
        if (rd_done) rd_done_n++;
        if (sta_done) sta_done_n++;
        if (ee_sk && !ee_cs) bad_gate++;
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic word_read(input int a);
        int cyc;
        int h;
        h = int'(step_div);
        sk_bad = 0;
        @(negedge clk);
        rd_start = 1'b1;
        rd_addr  = 6'(a);
        @(negedge clk);
        rd_start = 1'b0;
        cyc = 0;
        while (!rd_done) begin
            if (rd_busy) cyc++;
            @(negedge clk);
        end
        check("R5 word", rd_word == memf(a), rd_word, memf(a));
        check("R2 command", cap == {2'b00, 3'b110, 6'(a)}, cap, {2'b00, 3'b110, 6'(a)});
        check("R4 duration", cyc == 57 * (h + 1), cyc, 57 * (h + 1));
        check("R2 clock count", sk_rises == 27, sk_rises, 27);
        check("R3 sk width", sk_bad == 0, sk_bad, 0);
        @(negedge clk);
        check("R6 pulse", !rd_done && rd_word == memf(a), rd_done, 0);
        check("R1 idle lines", {ee_cs, ee_sk, ee_di, rd_busy} == 4'b0,
              {ee_cs, ee_sk, ee_di, rd_busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int rd0, sd0;
        logic [47:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", {ee_cs, ee_sk, ee_di, rd_busy, rd_done, sta_done} == 6'b0,
              {ee_cs, ee_sk, ee_di, rd_busy, rd_done, sta_done}, 0);

        // R5 R2 R4: exhaustive address sweep at the shortest step
        for (int a = 0; a < 64; a++) word_read(a);

        // R3: longer steps
        step_div = 8'd2;
        word_read(0);
        word_read(21);
        word_read(63);

        // R7: strobes during a running read are ignored
        step_div = 8'd1;
        rd0 = rd_done_n;
        @(negedge clk);
        rd_start = 1'b1; rd_addr = 6'd5;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (20) @(negedge clk);
        rd_start = 1'b1; rd_addr = 6'd40; sta_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0; sta_start = 1'b0;
        while (!rd_done) @(negedge clk);
        check("R7 word kept", rd_word == memf(5), rd_word, memf(5));
        check("R7 command kept", cap[5:0] == 6'd5, cap[5:0], 5);
        sd0 = sta_done_n;
        repeat (300) @(negedge clk);
        check("R7 no extra read", rd_done_n == rd0 + 1 && !rd_busy, rd_done_n - rd0, 1);
        check("R7 no station", sta_done_n == sd0, sta_done_n - sd0, 0);

        // R8 R10: station address fetch
        exp = '0;
        for (int j = 0; j < 3; j++) begin
            int w, p;
            w = int'(memf(7 + j));
            p = int'(memf(6 + j));
            exp[16*j +: 8]     = 8'(((w << 1) + (p >> 15)) & 255);
            exp[16*j + 8 +: 8] = 8'((w >> 7) & 255);
        end
        rd0 = rd_done_n;
        sd0 = sta_done_n;
        sk_bad = 0;
        @(negedge clk);
        sta_start = 1'b1;
        @(negedge clk);
        sta_start = 1'b0;
        while (!sta_done) @(negedge clk);
        check("R8 station address", sta_addr == exp, sta_addr, exp);
        check("R10 no word strobe", rd_done_n == rd0, rd_done_n - rd0, 0);
        check("R8 last command", cap == {2'b00, 3'b110, 6'd9}, cap, {2'b00, 3'b110, 6'd9});
        check("R3 sk width station", sk_bad == 0, sk_bad, 0);
        @(negedge clk);
        check("R8 done pulse", !sta_done && sta_done_n == sd0 + 1, sta_done_n - sd0, 1);
        check("R9 sk gated", bad_gate == 0, bad_gate, 0);
        check("R1 idle after station", {ee_cs, ee_sk, ee_di, rd_busy} == 4'b0,
              {ee_cs, ee_sk, ee_di, rd_busy}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule